// File: doc/BRIEF.md
# Serially Programmed Channel Enable Register

This block is a two-wire serial bus slave that owns a single 8-bit enable register. Each register bit drives one channel-enable output, so a bus master can open or close any set of channels at once. The slave filters and samples the clock and data lines with the system clock, finds START and STOP conditions, and matches a 7-bit device address. It acknowledges writes into the register and returns the register on reads. The data line is driven only through an open-drain style drive-low enable.

There is no pointer or subaddress byte. Every byte that follows an accepted write address lands directly in the register, so the last byte of a transaction wins. A new pattern reaches the outputs only at the moment the slave drives the acknowledge for that byte. The active-low reset input is asynchronous. It opens every channel and returns the bus logic to idle, and it also stands in for power-on.

Top module: `chan_en_reg`

## Requirements
- R1: The device address is the 7-bit value {1110, strap[2], strap[1], strap[0]}, sent MSB first and followed by a direction bit (1 = read, 0 = write). A matching address is acknowledged by pulling SDA low during the ninth clock. Any other address, including one whose upper four bits differ, is not acknowledged, and the bytes that follow it are neither acknowledged nor stored until the next START.
- R2: After an acknowledged write address, every data byte is acknowledged and stored. When several bytes arrive in one transaction, the register ends up holding the last one.
- R3: The channel outputs do not change while a data byte is shifting in. They take the new value only once the acknowledge for that byte is being driven.
- R4: After an acknowledged read address, the slave sends the register MSB first. If the master acknowledges, the slave sends the register again. After a not-acknowledge the slave releases SDA.
- R5: Register bit n drives chan_en[n] directly (1 = channel closed, 0 = open), and any combination of bits may be set.
- R6: While rst_n is low, the register reads all zeros, SDA is released and the bus logic is idle. This also holds right after the first reset.
- R7: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START at any point, including a repeated START, restarts address reception. A STOP returns to idle with SDA released.
- R8: A pulse on SCL or SDA shorter than FILT_NS (50 ns by default, converted to clock cycles from CLK_HZ) has no effect on the transfer.
- R9: The slave changes its SDA drive only while SCL is low, and no sooner than HOLD_NS (300 ns by default) after SCL falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap | input | 3 | Board straps that form the low three address bits |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 leaves it released |
| chan_en | output | 8 | Channel enables, bit n for channel n |

## Verification
A wrong address or direction state shows up within the ninth clock of the address byte as a missing or extra acknowledge. A bad shift or bit counter shows up at the next acknowledge, where chan_en takes a value other than the byte sent, or in the first read-back, where the serial data differ from the register. A hold-timer or drive-state fault shows up in the same bit as a change of sda_drive_low that comes too soon after SCL falls or while SCL is high. A stuck drive after a not-acknowledge or a STOP shows up as SDA held low in the following idle period.

// File: rtl/chen_pkg.sv
package chen_pkg;

    // one register, one protocol byte
    localparam int REG_W  = 8;
    localparam int BYTE_W = 8;

    // upper part of the device address, fixed by the protocol
    localparam logic [3:0] ADDR_HI = 4'b1110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK
    } bus_st_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [6:0] rx, input logic [2:0] strap);
        return rx == {ADDR_HI, strap};
    endfunction

    // nanoseconds to clock cycles, rounded up, never below one
    function automatic int unsigned ns_to_cyc(input int unsigned clk_hz, input int unsigned ns);
        int unsigned c;
        c = ((clk_hz / 1000) * ns + 999_999) / 1_000_000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/chen_line_filter.sv
module chen_line_filter #(
    parameter int unsigned STABLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int unsigned CW = $clog2(STABLE_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    // two-flop synchronizer, then the output follows only a level held long enough
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            run_q  <= '0;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] == line_o) begin
                run_q <= '0;
            end else if (run_q == CW'(STABLE_CYC - 1)) begin
                run_q  <= '0;
                line_o <= sync_q[1];
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/chen_bus_events.sv
module chen_bus_events
    import chen_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        evt.start = scl_f & scl_q & sda_q & ~sda_f;
        evt.stop  = scl_f & scl_q & ~sda_q & sda_f;
        evt.rise  = scl_f & ~scl_q;
        evt.fall  = ~scl_f & scl_q;
    end

endmodule

// File: rtl/chen_slave_ctl.sv
module chen_slave_ctl
    import chen_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_evt_t         evt,
    input  logic             sda_f,
    input  logic [2:0]       strap,
    output logic             sda_drive_low,
    output logic [REG_W-1:0] en_q,
    output bus_st_t          st
);
    localparam int unsigned HOLD_LD = (HOLD_CYC < 1) ? 1 : HOLD_CYC;
    localparam int unsigned HW      = $clog2(HOLD_LD + 1);

    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rw_q;
    logic              mack_q;
    logic              want_q;   // level wanted on SDA once the hold time is over
    logic [HW-1:0]     hold_q;
    logic              drive_q;

    assign sda_drive_low = drive_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            want_q  <= 1'b1;
            hold_q  <= '0;
            drive_q <= 1'b0;
            en_q    <= '0;
        end else if (evt.start || evt.stop) begin
            drive_q <= 1'b0;
            want_q  <= 1'b1;
            hold_q  <= '0;
            bit_cnt <= '0;
            st      <= evt.start ? ST_ADDR : ST_IDLE;
        end else begin
            // delayed SDA update after a clock fall; a write lands with its acknowledge
            if (hold_q != '0) begin
                if (hold_q == HW'(1)) begin
                    drive_q <= ~want_q;
                    if (st == ST_WR_ACK) begin
                        en_q <= rx_sh;
                    end
                end
                hold_q <= hold_q - 1'b1;
            end

            if (evt.rise) begin
                case (st)
                    ST_ADDR, ST_WR_DATA: begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_f};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_RD_DATA: bit_cnt <= bit_cnt + 1'b1;
                    ST_RD_ACK:  mack_q  <= ~sda_f;
                    default: ;
                endcase
            end

            if (evt.fall) begin
                hold_q <= HW'(HOLD_LD);
                case (st)
                    ST_ADDR: begin
                        if (bit_cnt == 4'd8) begin
                            if (addr_hit(rx_sh[7:1], strap)) begin
                                rw_q   <= rx_sh[0];
                                st     <= ST_ADDR_ACK;
                                want_q <= 1'b0;
                            end else begin
                                st     <= ST_IDLE;
                                want_q <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        bit_cnt <= '0;
                        if (rw_q) begin
                            st     <= ST_RD_DATA;
                            tx_sh  <= en_q;
                            want_q <= en_q[BYTE_W-1];
                        end else begin
                            st     <= ST_WR_DATA;
                            want_q <= 1'b1;
                        end
                    end
                    ST_WR_DATA: begin
                        if (bit_cnt == 4'd8) begin
                            st     <= ST_WR_ACK;
                            want_q <= 1'b0;
                        end
                    end
                    ST_WR_ACK: begin
                        st      <= ST_WR_DATA;
                        bit_cnt <= '0;
                        want_q  <= 1'b1;
                    end
                    ST_RD_DATA: begin
                        if (bit_cnt == 4'd8) begin
                            st     <= ST_RD_ACK;
                            want_q <= 1'b1;
                        end else begin
                            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                            want_q <= tx_sh[BYTE_W-2];
                        end
                    end
                    ST_RD_ACK: begin
                        if (mack_q) begin
                            st      <= ST_RD_DATA;
                            bit_cnt <= '0;
                            tx_sh   <= en_q;
                            want_q  <= en_q[BYTE_W-1];
                        end else begin
                            st     <= ST_IDLE;
                            want_q <= 1'b1;
                        end
                    end
                    default: want_q <= 1'b1;
                endcase
            end
        end
    end

endmodule

// File: rtl/chan_en_reg.sv
module chan_en_reg
    import chen_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned FILT_NS = 50,
    parameter int unsigned HOLD_NS = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [2:0]       strap,
    output logic             sda_drive_low,
    output logic [REG_W-1:0] chan_en
);
    localparam int unsigned FILT_CYC = ns_to_cyc(CLK_HZ, FILT_NS);
    localparam int unsigned HOLD_CYC = ns_to_cyc(CLK_HZ, HOLD_NS);
    localparam int          N_LINES  = 2;

    logic [N_LINES-1:0] raw_l;
    logic [N_LINES-1:0] flt_l;
    bus_evt_t           evt;
    bus_st_t            bus_st;

    assign raw_l = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_flt
        chen_line_filter #(
            .STABLE_CYC(FILT_CYC)
        ) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_l[g]),
            .line_o(flt_l[g])
        );
    end

    chen_bus_events u_evt (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_f(flt_l[1]),
        .sda_f(flt_l[0]),
        .evt  (evt)
    );

    chen_slave_ctl #(
        .HOLD_CYC(HOLD_CYC)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (evt),
        .sda_f        (flt_l[0]),
        .strap        (strap),
        .sda_drive_low(sda_drive_low),
        .en_q         (chan_en),
        .st           (bus_st)
    );

endmodule

// File: rtl/chen_reg_chk.sv
module chen_reg_chk
    import chen_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_drive_low,
    input logic [REG_W-1:0] chan_en,
    input bus_st_t          bus_st
);
    localparam int unsigned CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] low_run;

    // consecutive cycles with the raw clock line low, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (scl_i) begin
            low_run <= '0;
        end else if (low_run != CW'(HOLD_CYC)) begin
            low_run <= low_run + 1'b1;
        end
    end

    a_r6_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (chan_en == '0 && !sda_drive_low));

    a_r3_en_moves_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en != $past(chan_en)) |-> sda_drive_low);

    a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low != $past(sda_drive_low)) |-> !scl_i);

    a_r9_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low != $past(sda_drive_low)) |-> (low_run >= CW'(HOLD_CYC)));

    a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_st == ST_IDLE || bus_st == ST_ADDR) |-> !sda_drive_low);

endmodule

bind chan_en_reg chen_reg_chk #(
    .HOLD_CYC(HOLD_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_i),
    .sda_drive_low(sda_drive_low),
    .chan_en      (chan_en),
    .bus_st       (bus_st)
);

// File: tb/test_chan_en_reg.sv
module test_chan_en_reg;

    localparam int unsigned CLK_HZ   = 250_000_000;
    localparam int          Q        = 55;   // quarter of an SCL period, in clocks
    localparam int          HOLD_EXP = 75;   // 300 ns at 4 ns per clock

    logic       clk   = 1'b0;
    logic       rst_n = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_drive_low;
    logic [7:0] chan_en;
    wire        sda_line = sda_m & ~sda_drive_low;

    always #2 clk = ~clk;

    chan_en_reg #(.CLK_HZ(CLK_HZ)) i_chan_en_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .strap        (strap),
        .sda_drive_low(sda_drive_low),
        .chan_en      (chan_en)
    );

    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] model = 8'h00;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rd);
        return {4'b1110, s, rd};
    endfunction

    // drive-change timing monitor for R9
    int   since_fall = 0;
    int   hold_bad   = 0;
    logic drv_prev   = 1'b0;
    always @(negedge clk) begin
        #1;
        if (scl_m) since_fall = 0;
        else       since_fall = since_fall + 1;
        if (rst_n && sda_drive_low !== drv_prev) begin
            if (scl_m || since_fall < HOLD_EXP) hold_bad++;
        end
        drv_prev = sda_drive_low;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // gm: 0 clean, 1 short SCL pulse in the low phase, 2 short SDA pulse in the high phase
    task automatic put_bit(input logic b, input int gm);
        tick(Q); sda_m = b;
        if (gm == 1) begin
            tick(20); scl_m = 1'b1; tick(8); scl_m = 1'b0; tick(Q - 28);
        end else begin
            tick(Q);
        end
        scl_m = 1'b1;
        if (gm == 2) begin
            tick(20); sda_m = ~b; tick(8); sda_m = b; tick(Q - 28);
        end else begin
            tick(Q);
        end
        tick(Q); scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_line; tick(Q); scl_m = 1'b0;
    endtask

    task automatic start_c();
        tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0;
    endtask

    task automatic stop_c();
        tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic glitch, output logic ack, output logic moved);
        logic [7:0] entry;
        logic       a;
        entry = chan_en;
        moved = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            put_bit(b[i], !glitch ? 0 : (i == 4) ? 1 : (i == 2) ? 2 : 0);
            if (chan_en !== entry) moved = 1'b1;
        end
        get_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        for (int i = 7; i >= 0; i--) begin
            logic v;
            get_bit(v);
            b[i] = v;
        end
        put_bit(mack ? 1'b0 : 1'b1, 0);
    endtask

    task automatic write_txn(input logic [2:0] s, input logic [7:0] d0, input logic [7:0] d1,
                             input logic [7:0] d2, input int n, input logic glitch);
        logic ack, moved;
        logic [7:0] d;
        start_c();
        send_byte(addr_byte(s, 1'b0), 1'b0, ack, moved);
        check("R1", "write address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
            send_byte(d, glitch, ack, moved);
            check("R2", "data byte ack", ack, 1);
            check("R3", "enables moved during shift", moved, 0);
            model = d;
            check(glitch ? "R8" : "R5", "chan_en after ack", chan_en, model);
        end
        stop_c();
        check("R7", "SDA released after STOP", sda_drive_low, 0);
    endtask

    task automatic read_txn(input logic [2:0] s, input int n);
        logic ack, moved;
        logic [7:0] b;
        start_c();
        send_byte(addr_byte(s, 1'b1), 1'b0, ack, moved);
        check("R1", "read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k < n - 1);
            check("R4", "read data", b, model);
        end
        check("R4", "SDA released after NACK", sda_drive_low, 0);
        stop_c();
    endtask

    initial begin
        repeat (190_000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic       ack, moved;
        logic [7:0] b;
        logic [6:0] bad_a;
        void'($urandom(32'd1234));

        #1 rst_n = 1'b0;
        tick(10);
        check("R6", "chan_en in reset", chan_en, 0);
        check("R6", "SDA in reset", sda_drive_low, 0);
        rst_n = 1'b1;
        tick(10);
        check("R6", "chan_en after reset", chan_en, 0);

        // basic write and read back
        write_txn(strap, 8'hA5, 8'h00, 8'h00, 1, 1'b0);
        read_txn(strap, 1);

        // several bytes: last one wins; all-ones and one-hot patterns
        write_txn(strap, 8'hFF, 8'h01, 8'h4C, 3, 1'b0);
        check("R2", "last byte kept", chan_en, 8'h4C);
        read_txn(strap, 3);

        // wrong low bits, then wrong fixed nibble: no ack, nothing stored
        for (int t = 0; t < 2; t++) begin
            bad_a = (t == 0) ? {4'b1110, ~strap} : {4'b1111, strap};
            start_c();
            send_byte({bad_a, 1'b0}, 1'b0, ack, moved);
            check("R1", "foreign address nack", ack, 0);
            send_byte(8'h33, 1'b0, ack, moved);
            check("R1", "byte after foreign address nack", ack, 0);
            stop_c();
            check("R1", "chan_en untouched", chan_en, model);
        end

        // repeated START: write a byte, then turn around into a read
        start_c();
        send_byte(addr_byte(strap, 1'b0), 1'b0, ack, moved);
        send_byte(8'h96, 1'b0, ack, moved);
        model = 8'h96;
        check("R2", "byte before repeated start", chan_en, model);
        start_c();
        send_byte(addr_byte(strap, 1'b1), 1'b0, ack, moved);
        check("R7", "address ack after repeated START", ack, 1);
        recv_byte(b, 1'b0);
        check("R7", "read after repeated START", b, model);
        stop_c();

        // short pulses on both lines inside a byte
        write_txn(strap, 8'h6B, 8'h00, 8'h00, 1, 1'b1);
        read_txn(strap, 1);

        // new strap value changes the address
        strap = 3'b010;
        write_txn(strap, 8'h18, 8'h00, 8'h00, 1, 1'b0);

        // reset in the middle of a byte
        start_c();
        send_byte(addr_byte(strap, 1'b0), 1'b0, ack, moved);
        send_byte(8'h3C, 1'b0, ack, moved);
        for (int i = 0; i < 3; i++) put_bit(1'b0, 0);
        tick(5);
        rst_n = 1'b0;
        tick(2);
        check("R6", "chan_en after mid-transfer reset", chan_en, 0);
        check("R6", "SDA after mid-transfer reset", sda_drive_low, 0);
        rst_n = 1'b1;
        model = 8'h00;
        tick(5);
        stop_c();
        read_txn(strap, 1);

        // random patterns and byte counts
        for (int r = 0; r < 6; r++) begin
            logic [7:0] x0, x1;
            int         nb;
            x0 = 8'($urandom);
            x1 = 8'($urandom);
            nb = $urandom_range(1, 2);
            write_txn(strap, x0, x1, 8'h00, nb, 1'b0);
            check("R5", "random chan_en", chan_en, (nb == 1) ? x0 : x1);
            if (r % 2 == 0) read_txn(strap, 1);
        end

        check("R9", "hold or high-phase drive changes", hold_bad, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule